// File: doc/BRIEF.md
# Oscillator Stabilization Wait Timer

This block keeps a freshly started oscillator away from the rest of the chip until it has had time to settle. When the oscillator enable goes high, the block counts a programmable number of the oscillator's own rising edges. It then raises a clock-enable in the oscillator domain, which downstream gating logic uses to pass the clock on. A copy of that ready condition is brought into the system clock domain through a two-flop synchronizer, so that control logic there can see when the source is usable.

The wait length comes from a 2-bit select in inverse order. A larger code gives a shorter wait: 8, 16, 32 or 64 cycles, and 64 after reset. For an external clock that is already stable, the wait circuit can be switched off, and the clock is then released as soon as the local reset is lifted. The select and the wait-circuit enable are captured once at the start of each enable period. Clearing the oscillator enable returns the oscillator side to its idle state at once, through a reset that is asserted asynchronously and released in step with the oscillator clock.

Top module: `osc_stab_wait`

## Requirements
- R1: While `sys_rst_n` is low, or while `osc_en` is low, `osc_clk_en` is 0. Once `osc_en` has been low for at least three system clock cycles, `osc_ready` is also 0.
- R2: With `wait_sel` = 0 and `wait_en` = 1 when `osc_en` rises, `osc_clk_en` first reads 1 after the 67th rising edge of `osc_clk` that follows the rise of `osc_en`. This is 2 edges of reset release, 1 load edge and 64 counted edges.
- R3: With `wait_en` = 1, a `wait_sel` of 3, 2 or 1 gives a first `osc_clk_en` after osc edge 11, 19 or 35 respectively. These are waits of 8, 16 and 32 cycles.
- R4: With `wait_en` = 0 when `osc_en` rises, no wait is applied, and `osc_clk_en` first reads 1 after osc edge 3 whatever the value of `wait_sel`.
- R5: The wait is counted in `osc_clk` edges, so the edge count of R2 and R3 does not depend on the ratio of the oscillator period to the system clock period.
- R6: Clearing `osc_enable` drops `osc_clk_en` at once, without waiting for an `osc_clk` edge. This holds both during a count and after release. A later rise of `osc_en` starts the full wait again from the beginning.
- R7: `osc_ready` is 0 whenever `osc_clk_en` has not yet risen in the current enable period. It reads 1 within three system clock cycles after `osc_clk_en` rises.
- R8: `wait_sel` and `wait_en` are captured when the wait starts. Changes to them during a count do not alter the release edge.
- R9: Once released, `osc_clk_en` stays 1 while `osc_en` stays high, even when `wait_sel` or `wait_en` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low chip reset |
| osc_clk | input | 1 | Free-running raw oscillator clock |
| osc_en | input | 1 | Oscillator enable; a rise starts a new wait |
| wait_sel | input | SEL_W (2) | Wait select: 3=8, 2=16, 1=32, 0=64 cycles |
| wait_en | input | 1 | 1 applies the wait, 0 bypasses it |
| osc_clk_en | output | 1 | Clock-enable in the oscillator domain |
| osc_ready | output | 1 | Ready flag synchronized to `sys_clk` |

## Verification
All four select codes are run with the wait circuit on, and each is checked for its exact release edge. This separates a correct decode from one that is reversed or off by one. Bypass runs with both a short and a long select confirm that the select is ignored when the wait is skipped. Repeating one select at a slow and at a fast oscillator period shows that the count follows the oscillator and not the system clock. Flipping the select and bypass mid-count, cutting the enable mid-count and after release, and changing inputs after release expose a missing capture, a counter that does not clear, and a release that is not sticky.

// File: rtl/osw_pkg.sv
`timescale 1ns/1ps
package osw_pkg;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_READY = 2'd2
  } osw_state_e;

  // Inverse-ordered power of two: code 0 gives the longest wait.
  function automatic int unsigned wait_len(input int unsigned max_log2,
                                           input int unsigned code);
    return 32'd1 << (max_log2 - code);
  endfunction

endpackage

// File: rtl/osw_sync.sv
`timescale 1ns/1ps
module osw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/osw_counter.sv
`timescale 1ns/1ps
module osw_counter
  import osw_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int MAX_LOG2 = 6,
  localparam int CNT_W   = MAX_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] wait_sel,
  input  logic             wait_en,
  output logic             released
);

  osw_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             wen_q, wen_d;
  logic [CNT_W-1:0] last_cnt;

  always_comb last_cnt = CNT_W'(wait_len(MAX_LOG2, int'(sel_q)) - 32'd1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sel_d   = sel_q;
    wen_d   = wen_q;
    case (state_q)
      ST_LOAD: begin
        sel_d   = wait_sel;
        wen_d   = wait_en;
        cnt_d   = '0;
        state_d = wait_en ? ST_COUNT : ST_READY;
      end
      ST_COUNT: begin
        if (cnt_q == last_cnt) state_d = ST_READY;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_READY: ;
      default: state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
      sel_q   <= '0;
      wen_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sel_q   <= sel_d;
      wen_q   <= wen_d;
    end
  end

  assign released = (state_q == ST_READY);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT) |-> (cnt_q <= last_cnt)); // R2

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY) |=> (state_q == ST_READY)); // R9

  AST_SEL_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_LOAD) |=> ($stable(sel_q) && $stable(wen_q))); // R8

  AST_RELEASE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(released) |-> (!wen_q || ($past(cnt_q) == last_cnt))); // R3

endmodule

// File: rtl/osc_stab_wait.sv
`timescale 1ns/1ps
module osc_stab_wait #(
  parameter int SEL_W       = 2,
  parameter int MAX_LOG2    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             osc_clk,
  input  logic             osc_en,
  input  logic [SEL_W-1:0] wait_sel,
  input  logic             wait_en,
  output logic             osc_clk_en,
  output logic             osc_ready
);

  logic osc_arst_n;
  logic osc_rst_n;
  logic released;

  assign osc_arst_n = sys_rst_n & osc_en;

  osw_sync #(.STAGES(SYNC_STAGES)) u_osc_rst_sync (
    .clk    (osc_clk),
    .arst_n (osc_arst_n),
    .d      (1'b1),
    .q      (osc_rst_n)
  );

  osw_counter #(.SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2)) u_counter (
    .clk      (osc_clk),
    .rst_n    (osc_rst_n),
    .wait_sel (wait_sel),
    .wait_en  (wait_en),
    .released (released)
  );

  assign osc_clk_en = released & osc_arst_n;

  osw_sync #(.STAGES(SYNC_STAGES)) u_ready_sync (
    .clk    (sys_clk),
    .arst_n (sys_rst_n),
    .d      (osc_clk_en),
    .q      (osc_ready)
  );

endmodule

// File: tb/osc_stab_wait_tb.sv
`timescale 1ns/1ps
module osc_stab_wait_tb;

  logic       sys_clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       sys_rst_n;
  logic       osc_en;
  logic [1:0] wait_sel;
  logic       wait_en;
  logic       osc_clk_en;
  logic       osc_ready;

  realtime osc_half = 7.0;
  int      checks = 0;
  int      errors = 0;
  bit      done   = 1'b0;

  always #2.5 sys_clk = ~sys_clk;
  always #(osc_half) osc_clk = ~osc_clk;

  osc_stab_wait u_dut (
    .sys_clk    (sys_clk),
    .sys_rst_n  (sys_rst_n),
    .osc_clk    (osc_clk),
    .osc_en     (osc_en),
    .wait_sel   (wait_sel),
    .wait_en    (wait_en),
    .osc_clk_en (osc_clk_en),
    .osc_ready  (osc_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Disable, then enable and count osc edges until release.
  task automatic run_wait(input logic [1:0] sel, input logic wen, input int exp_edges,
                          input string req, input bit flip_mid);
    int  first;
    bit  early;
    first = -1;
    early = 1'b0;
    osc_en = 1'b0;
    repeat (6) @(posedge sys_clk);
    @(negedge osc_clk);
    chk(osc_clk_en == 1'b0 && osc_ready == 1'b0, "R1 idle", int'({osc_clk_en, osc_ready}), 0);
    wait_sel = sel;
    wait_en  = wen;
    osc_en   = 1'b1;
    for (int k = 1; k <= 200; k++) begin
      @(negedge osc_clk);
      if (flip_mid && k == 5) begin
        wait_sel = ~sel;
        wait_en  = ~wen;
      end
      if (osc_ready && !osc_clk_en) early = 1'b1;
      if (osc_clk_en) begin
        first = k;
        break;
      end
    end
    chk(first == exp_edges, req, first, exp_edges);
    chk(!early, "R7 no early ready", int'(early), 0);
    repeat (3) @(posedge sys_clk);
    #1;
    chk(osc_ready == 1'b1, "R7 ready synced", int'(osc_ready), 1);
  endtask

  task automatic test_reset();
    sys_rst_n = 1'b0;
    osc_en    = 1'b1;
    wait_sel  = 2'd0;
    wait_en   = 1'b1;
    repeat (10) @(posedge sys_clk);
    #1;
    chk(osc_clk_en == 1'b0, "R1 reset clk_en", int'(osc_clk_en), 0);
    chk(osc_ready == 1'b0, "R1 reset ready", int'(osc_ready), 0);
    osc_en = 1'b0;
    #1;
    sys_rst_n = 1'b1;
  endtask

  task automatic test_codes();
    run_wait(2'd0, 1'b1, 67, "R2 code0 64 cycles", 1'b0);
    run_wait(2'd3, 1'b1, 11, "R3 code3 8 cycles", 1'b0);
    run_wait(2'd2, 1'b1, 19, "R3 code2 16 cycles", 1'b0);
    run_wait(2'd1, 1'b1, 35, "R3 code1 32 cycles", 1'b0);
  endtask

  task automatic test_bypass();
    run_wait(2'd0, 1'b0, 3, "R4 bypass code0", 1'b0);
    run_wait(2'd3, 1'b0, 3, "R4 bypass code3", 1'b0);
  endtask

  task automatic test_osc_period();
    osc_half = 11.0;
    run_wait(2'd2, 1'b1, 19, "R5 slow osc", 1'b0);
    osc_half = 3.0;
    run_wait(2'd2, 1'b1, 19, "R5 fast osc", 1'b0);
    osc_half = 7.0;
  endtask

  task automatic test_capture();
    run_wait(2'd0, 1'b1, 67, "R8 flip during count", 1'b0 | 1'b1);
  endtask

  task automatic test_sticky();
    run_wait(2'd3, 1'b1, 11, "R3 code3 again", 1'b0);
    wait_sel = 2'd0;
    wait_en  = 1'b0;
    repeat (20) @(negedge osc_clk);
    chk(osc_clk_en == 1'b1, "R9 hold after input change", int'(osc_clk_en), 1);
    chk(osc_ready == 1'b1, "R9 ready held", int'(osc_ready), 1);
  endtask

  task automatic test_disable();
    // after release: immediate drop
    run_wait(2'd3, 1'b1, 11, "R3 code3 pre-drop", 1'b0);
    #1.3;
    osc_en = 1'b0;
    #0.2;
    chk(osc_clk_en == 1'b0, "R6 async drop after release", int'(osc_clk_en), 0);
    // mid-count drop, then full restart
    repeat (4) @(posedge sys_clk);
    @(negedge osc_clk);
    wait_sel = 2'd0;
    wait_en  = 1'b1;
    osc_en   = 1'b1;
    repeat (40) @(negedge osc_clk);
    osc_en = 1'b0;
    #0.2;
    chk(osc_clk_en == 1'b0, "R6 drop mid count", int'(osc_clk_en), 0);
    run_wait(2'd0, 1'b1, 67, "R6 full restart", 1'b0);
  endtask

  initial begin
    test_reset();
    test_codes();
    test_bypass();
    test_osc_period();
    test_capture();
    test_sticky();
    test_disable();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule